// File: doc/BRIEF.md
# AUX request to I2C bridge

This block serves requests from a display sink's auxiliary channel and carries each one out either as a run of single-byte accesses to a local register space or as a transaction on a byte-level I2C master. A request gives a 4-bit command, a 20-bit address, a length of 1 to 16 bytes and a 16-byte data buffer. The block answers with a reply code and the buffer. Bytes that were read replace their slots in the buffer, and every other byte comes back unchanged.

The I2C side is driven one command at a time: start with device address and direction, one byte, or stop. The block remembers whether a transaction is still open on the I2C bus after a "middle of transaction" request. It also remembers the address and direction of the last such request. A later middle-of-transaction request to the same target in the same direction continues the open transaction without a new start. A change of target or direction closes the transaction and opens a new one.

Top module: `aux_i2c_bridge`

## Requirements
- R1: Command codes are 4'h8 native write, 4'h9 native read, 4'h0 I2C write, 4'h1 I2C read, 4'h4 continuing I2C write and 4'h5 continuing I2C read. Every other code is answered with reply code 1 (NACK) two cycles after acceptance, with no register access and no I2C command in between.
- R2: `req_ready` is high only while the block is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `rsp_valid` is a one-cycle pulse, and `req_ready` is high in the following cycle.
- R3: A native request performs one register access per cycle, `reg_en` high, for bytes 0 to len-1 in order. The first access is at the request address and each later one is at the previous address plus 1. Byte i of the buffer is `req_data[8*i+7:8*i]`, and it is written for 4'h8 or replaced by `reg_rdata` for 4'h9.
- R4: A native request stops at the first access with `reg_err` high and replies 1 (NACK). Bytes read before the error are kept in the buffer. If every access succeeds, the reply is 0 (ACK).
- R5: A plain I2C request (4'h0, 4'h1) first issues a stop if a transaction is open. It then issues a start with device `addr[6:0]` and `i2c_rd` equal to command bit 0.
- R6: A plain I2C request whose start is not acknowledged replies 4 (I2C-NACK) without a stop. Otherwise it moves the bytes, ends at the first byte that is not acknowledged, and always issues a stop. The reply is 0 if every byte was acknowledged and 4 otherwise. After the request, no transaction is open.
- R7: A continuing request (4'h4, 4'h5) with no transaction open issues a start. If the start is not acknowledged, it replies 4, issues no stop, and leaves no transaction open.
- R8: A continuing request while a transaction is open issues a stop and a new start only when its full 20-bit address or its direction differs from the last continuing request. Otherwise its bytes follow at once, with no start.
- R9: A continuing request whose bytes are all acknowledged issues no stop, leaves the transaction open and replies 0.
- R10: A continuing request whose byte is not acknowledged issues a stop, replies 4 and leaves no transaction open.
- R11: During an I2C read, byte i of the buffer takes `i2c_rbyte` of the i-th acknowledged byte. During an I2C write, byte i of the buffer is presented on `i2c_wbyte`.
- R12: An I2C command (op 0 start, 1 byte, 2 stop) is held on `i2c_valid`, `i2c_op`, `i2c_rd`, `i2c_dev` and `i2c_wbyte` until a cycle with `i2c_done` high. `i2c_nak` and `i2c_rbyte` are read in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_cmd | input | 4 | Command code |
| req_addr | input | 20 | Register address or I2C target |
| req_len | input | 5 | Byte count, 1 to 16 |
| req_data | input | 128 | Request buffer, byte i at bits 8i+7:8i |
| rsp_valid | output | 1 | Reply pulse |
| rsp_code | output | 3 | 0 ACK, 1 NACK, 4 I2C-NACK |
| rsp_data | output | 128 | Buffer after the request |
| reg_en | output | 1 | Register access this cycle |
| reg_we | output | 1 | Access is a write |
| reg_addr | output | 20 | Access address |
| reg_wdata | output | 8 | Write byte |
| reg_rdata | input | 8 | Read byte, same cycle |
| reg_err | input | 1 | Access failed, same cycle |
| i2c_valid | output | 1 | I2C command pending |
| i2c_op | output | 2 | 0 start, 1 byte, 2 stop |
| i2c_rd | output | 1 | Direction, 1 for read |
| i2c_dev | output | 7 | Device address for start |
| i2c_wbyte | output | 8 | Byte to send |
| i2c_done | input | 1 | Command finished |
| i2c_nak | input | 1 | Command not acknowledged |
| i2c_rbyte | input | 8 | Byte received |

## Verification
The bench follows a continuing write with the same write, a read to the same target, a read to another target, a target that differs only above bit 6, and a plain request. A design that compares too little state would skip a needed restart or add a needless one, and the recorded sequence of I2C commands would then differ. A byte failure in the middle of a continuing read and a start failure with a transaction open both check that the open flag is cleared. Without that, the next request would leave out its start or send a stray stop. A native read that runs into the failing region checks the early stop and the partly filled buffer, and unknown codes, including a continuing code with the native bit set, check that no bus is touched.

// File: rtl/aux_i2c_bridge.sv
module aux_i2c_bridge #(
  parameter int ADDR_W  = 20,
  parameter int MAX_LEN = 16,
  parameter int DEV_W   = 7,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int IDX_W  = $clog2(MAX_LEN),
  localparam int BUF_W  = MAX_LEN * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [BUF_W-1:0]  req_data,
  output logic              rsp_valid,
  output logic [2:0]        rsp_code,
  output logic [BUF_W-1:0]  rsp_data,
  output logic              reg_en,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata,
  input  logic              reg_err,
  output logic              i2c_valid,
  output logic [1:0]        i2c_op,
  output logic              i2c_rd,
  output logic [DEV_W-1:0]  i2c_dev,
  output logic [7:0]        i2c_wbyte,
  input  logic              i2c_done,
  input  logic              i2c_nak,
  input  logic [7:0]        i2c_rbyte
);

  localparam logic [2:0] RC_ACK     = 3'd0;
  localparam logic [2:0] RC_NACK    = 3'd1;
  localparam logic [2:0] RC_I2C_NAK = 3'd4;

  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_BYTE  = 2'd1;
  localparam logic [1:0] OP_STOP  = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_DECODE, S_NATIVE, S_CLOSE, S_START, S_XFER, S_FINISH, S_REPLY
  } state_t;

  state_t                      state;
  logic [3:0]                  cmd_q;
  logic [ADDR_W-1:0]           addr_q;
  logic [LEN_W-1:0]            len_q;
  logic [LEN_W-1:0]            idx_q;
  logic [MAX_LEN-1:0][7:0]     buf_q;
  logic [2:0]                  code_q;
  logic                        open_q;
  logic [ADDR_W-1:0]           last_addr_q;
  logic                        last_rd_q;

  wire is_native = (cmd_q == 4'h8) || (cmd_q == 4'h9);
  wire is_i2c    = (cmd_q[3] == 1'b0) && (cmd_q[1] == 1'b0);
  wire is_mot    = cmd_q[2];
  wire rd        = cmd_q[0];
  wire last_byte = (idx_q == len_q - LEN_W'(1));
  wire [IDX_W-1:0] bi = idx_q[IDX_W-1:0];
  wire restart   = (addr_q != last_addr_q) || (rd != last_rd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cmd_q       <= '0;
      addr_q      <= '0;
      len_q       <= '0;
      idx_q       <= '0;
      buf_q       <= '0;
      code_q      <= RC_ACK;
      open_q      <= 1'b0;
      last_addr_q <= '0;
      last_rd_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          cmd_q  <= req_cmd;
          addr_q <= req_addr;
          len_q  <= req_len;
          buf_q  <= req_data;
          state  <= S_DECODE;
        end
        S_DECODE: begin
          idx_q <= '0;
          if (is_native) state <= S_NATIVE;
          else if (is_i2c) begin
            if (!is_mot) state <= open_q ? S_CLOSE : S_START;
            else if (!open_q) state <= S_START;
            else if (restart) state <= S_CLOSE;
            else state <= S_XFER;
          end else begin
            code_q <= RC_NACK;
            state  <= S_REPLY;
          end
        end
        S_NATIVE: begin
          if (reg_err) begin
            code_q <= RC_NACK;
            state  <= S_REPLY;
          end else begin
            if (rd) buf_q[bi] <= reg_rdata;
            if (last_byte) begin
              code_q <= RC_ACK;
              state  <= S_REPLY;
            end else idx_q <= idx_q + LEN_W'(1);
          end
        end
        S_CLOSE: if (i2c_done) begin
          open_q <= 1'b0;
          state  <= S_START;
        end
        S_START: if (i2c_done) begin
          if (i2c_nak) begin
            open_q <= 1'b0;
            code_q <= RC_I2C_NAK;
            state  <= S_REPLY;
          end else begin
            open_q <= 1'b1;
            if (is_mot) begin
              last_addr_q <= addr_q;
              last_rd_q   <= rd;
            end
            state <= S_XFER;
          end
        end
        S_XFER: if (i2c_done) begin
          if (i2c_nak) begin
            code_q <= RC_I2C_NAK;
            state  <= S_FINISH;
          end else begin
            if (rd) buf_q[bi] <= i2c_rbyte;
            if (last_byte) begin
              code_q <= RC_ACK;
              state  <= is_mot ? S_REPLY : S_FINISH;
            end else idx_q <= idx_q + LEN_W'(1);
          end
        end
        S_FINISH: if (i2c_done) begin
          open_q <= 1'b0;
          state  <= S_REPLY;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_REPLY);
  assign rsp_code  = code_q;
  assign rsp_data  = buf_q;

  assign reg_en    = (state == S_NATIVE);
  assign reg_we    = ~rd;
  assign reg_addr  = addr_q + ADDR_W'(idx_q);
  assign reg_wdata = buf_q[bi];

  assign i2c_valid = (state == S_CLOSE) || (state == S_START) ||
                     (state == S_XFER)  || (state == S_FINISH);
  assign i2c_op    = (state == S_START) ? OP_START :
                     (state == S_XFER)  ? OP_BYTE  : OP_STOP;
  assign i2c_rd    = rd;
  assign i2c_dev   = addr_q[DEV_W-1:0];
  assign i2c_wbyte = buf_q[bi];

endmodule

// File: rtl/aux_i2c_bridge_checker.sv
module aux_i2c_bridge_checker #(
  parameter int ADDR_W = 20,
  parameter int DEV_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [3:0]        req_cmd,
  input logic              rsp_valid,
  input logic [2:0]        rsp_code,
  input logic              reg_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              i2c_valid,
  input logic              i2c_done,
  input logic [1:0]        i2c_op,
  input logic              i2c_rd,
  input logic [DEV_W-1:0]  i2c_dev,
  input logic [7:0]        i2c_wbyte
);

  a_r1_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(req_cmd inside {4'h0, 4'h1, 4'h4, 4'h5, 4'h8, 4'h9}))
      |=> (!reg_en && !i2c_valid) ##1 (rsp_valid && rsp_code == 3'd1));

  a_r2_reply_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_en, i2c_valid, rsp_valid, req_ready}));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && $past(reg_en)) |-> (reg_addr == $past(reg_addr) + ADDR_W'(1)));

  a_r4_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code inside {3'd0, 3'd1, 3'd4}));

  a_r12_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_valid && !i2c_done) |=> (i2c_valid && $stable(i2c_op) && $stable(i2c_rd) &&
                                  $stable(i2c_dev) && $stable(i2c_wbyte)));

endmodule

bind aux_i2c_bridge aux_i2c_bridge_checker #(.ADDR_W(ADDR_W), .DEV_W(DEV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_cmd(req_cmd), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
  .reg_en(reg_en), .reg_addr(reg_addr), .i2c_valid(i2c_valid),
  .i2c_done(i2c_done), .i2c_op(i2c_op), .i2c_rd(i2c_rd),
  .i2c_dev(i2c_dev), .i2c_wbyte(i2c_wbyte)
);

// File: tb/aux_i2c_bridge_bench.sv
module aux_i2c_bridge_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [3:0]   req_cmd = '0;
  logic [19:0]  req_addr = '0;
  logic [4:0]   req_len = '0;
  logic [127:0] req_data = '0;
  logic         rsp_valid;
  logic [2:0]   rsp_code;
  logic [127:0] rsp_data;
  logic         reg_en, reg_we;
  logic [19:0]  reg_addr;
  logic [7:0]   reg_wdata, reg_rdata;
  logic         reg_err;
  logic         i2c_valid, i2c_rd;
  logic [1:0]   i2c_op;
  logic [6:0]   i2c_dev;
  logic [7:0]   i2c_wbyte;
  logic         i2c_done = 1'b0, i2c_nak = 1'b0;
  logic [7:0]   i2c_rbyte = '0;

  aux_i2c_bridge u_aux_i2c_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_data(rsp_data),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_err(reg_err), .i2c_valid(i2c_valid), .i2c_op(i2c_op),
    .i2c_rd(i2c_rd), .i2c_dev(i2c_dev), .i2c_wbyte(i2c_wbyte), .i2c_done(i2c_done),
    .i2c_nak(i2c_nak), .i2c_rbyte(i2c_rbyte)
  );

  int compared = 0;
  int mismatched = 0;
  logic busy = 1'b0;
  int fail_k = 99;

  logic [32:0] exp_q[$];
  logic [32:0] act_q[$];

  function automatic logic [32:0] ev(input logic [1:0] kind, input logic [1:0] op,
                                     input logic r, input logic [19:0] a, input logic [7:0] d);
    return {kind, op, r, a, d};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // register space model
  logic [7:0] mem [0:255];
  logic [7:0] ref_mem [0:255];
  assign reg_err   = (reg_addr[19:16] == 4'hF);
  assign reg_rdata = mem[reg_addr[7:0]];
  always @(posedge clk) if (reg_en && reg_we && !reg_err) mem[reg_addr[7:0]] <= reg_wdata;

  // I2C target model and event monitor
  int lat = 0;
  int k_drv = 0;
  always @(negedge clk) begin
    i2c_done = 1'b0;
    i2c_nak  = 1'b0;
    if (!busy && rst_n && (reg_en || i2c_valid)) begin
      compared++;
      mismatched++;
      $display("FAIL R1 bus active while no request: actual=%0b%0b expected=00", reg_en, i2c_valid);
    end
    if (reg_en) act_q.push_back(ev(2'd0, 2'd0, !reg_we, reg_addr, reg_we ? reg_wdata : 8'h00));
    if (i2c_valid) begin
      lat++;
      if (lat == 2) begin
        lat = 0;
        i2c_done = 1'b1;
        case (i2c_op)
          2'd0: begin
            k_drv = 0;
            i2c_nak = !(i2c_dev == 7'h50 || i2c_dev == 7'h51);
            act_q.push_back(ev(2'd1, 2'd0, i2c_rd, {13'd0, i2c_dev}, 8'h00));
          end
          2'd1: begin
            if (i2c_rd) begin
              i2c_nak = (k_drv == fail_k);
              i2c_rbyte = 8'(i2c_dev) + 8'(k_drv);
            end else i2c_nak = (i2c_wbyte == 8'hEE);
            k_drv++;
            act_q.push_back(ev(2'd1, 2'd1, i2c_rd, 20'd0, i2c_rd ? 8'h00 : i2c_wbyte));
          end
          default: act_q.push_back(ev(2'd1, 2'd2, 1'b0, 20'd0, 8'h00));
        endcase
      end
    end else lat = 0;
  end

  // reference model state
  bit ref_open = 0;
  logic [19:0] ref_last_addr = '0;
  bit ref_last_rd = 0;
  int ref_k = 0;

  task automatic predict(input logic [3:0] cmd, input logic [19:0] addr, input int len,
                         input logic [127:0] data, output logic [2:0] code, output logic [127:0] od);
    bit r, mot, need, nak;
    logic [6:0] dev;
    logic [7:0] b;
    logic [19:0] a;
    od = data;
    code = 3'd1;
    if (cmd == 4'h8 || cmd == 4'h9) begin
      r = cmd[0];
      code = 3'd0;
      for (int i = 0; i < len; i++) begin
        a = addr + 20'(i);
        exp_q.push_back(ev(2'd0, 2'd0, r, a, r ? 8'h00 : data[8*i +: 8]));
        if (a[19:16] == 4'hF) begin code = 3'd1; break; end
        if (r) od[8*i +: 8] = ref_mem[a[7:0]];
        else ref_mem[a[7:0]] = data[8*i +: 8];
      end
    end else if (cmd inside {4'h0, 4'h1, 4'h4, 4'h5}) begin
      r = cmd[0]; mot = cmd[2]; dev = addr[6:0];
      need = 1;
      if (!mot) begin
        if (ref_open) exp_q.push_back(ev(2'd1, 2'd2, 1'b0, 20'd0, 8'h00));
        ref_open = 0;
      end else if (ref_open) begin
        if (addr != ref_last_addr || r != ref_last_rd) begin
          exp_q.push_back(ev(2'd1, 2'd2, 1'b0, 20'd0, 8'h00));
          ref_open = 0;
        end else need = 0;
      end
      if (need) begin
        exp_q.push_back(ev(2'd1, 2'd0, r, {13'd0, dev}, 8'h00));
        ref_k = 0;
        if (!(dev == 7'h50 || dev == 7'h51)) begin
          code = 3'd4; ref_open = 0; return;
        end
        ref_open = 1;
      end
      if (mot) begin ref_last_addr = addr; ref_last_rd = r; end
      code = 3'd0;
      for (int i = 0; i < len; i++) begin
        b = data[8*i +: 8];
        exp_q.push_back(ev(2'd1, 2'd1, r, 20'd0, r ? 8'h00 : b));
        nak = r ? (ref_k == fail_k) : (b == 8'hEE);
        if (!nak && r) od[8*i +: 8] = 8'(dev) + 8'(ref_k);
        ref_k++;
        if (nak) begin code = 3'd4; break; end
      end
      if (code != 3'd0 || !mot) begin
        exp_q.push_back(ev(2'd1, 2'd2, 1'b0, 20'd0, 8'h00));
        ref_open = 0;
      end
    end
  endtask

  task automatic run_req(input string tag, input logic [3:0] cmd, input logic [19:0] addr,
                         input int len, input logic [127:0] data, output int waits);
    logic [2:0] ecode;
    logic [127:0] edata;
    bit same;
    exp_q.delete();
    act_q.delete();
    predict(cmd, addr, len, data, ecode, edata);
    @(negedge clk);
    busy = 1'b1;
    req_valid = 1'b1; req_cmd = cmd; req_addr = addr; req_len = 5'(len); req_data = data;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    waits = 1;
    while (!rsp_valid && waits < 2000) begin
      @(negedge clk);
      waits++;
    end
    check(rsp_valid, {tag, " reply arrives"}, 128'(rsp_valid), 128'd1);
    check(rsp_code == ecode, {tag, " reply code"}, 128'(rsp_code), 128'(ecode));
    check(rsp_data == edata, {tag, " reply buffer"}, rsp_data, edata);
    same = (act_q.size() == exp_q.size());
    if (same) foreach (act_q[i]) if (act_q[i] != exp_q[i]) same = 0;
    check(same, {tag, " bus sequence"}, act_q.size() > 0 ? 128'(act_q[act_q.size()-1]) : 128'd0,
          exp_q.size() > 0 ? 128'(exp_q[exp_q.size()-1]) : 128'd0);
    if (!same) begin
      foreach (act_q[i]) $display("  act[%0d]=%0h", i, act_q[i]);
      foreach (exp_q[i]) $display("  exp[%0d]=%0h", i, exp_q[i]);
    end
    @(negedge clk);
    busy = 1'b0;
  endtask

  function automatic logic [127:0] pat(input int seed);
    logic [127:0] p;
    for (int i = 0; i < 16; i++) p[8*i +: 8] = 8'(seed * 37 + i * 11 + 3);
    return p;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int w;
    logic [127:0] d;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'hA5;
      ref_mem[i] = 8'(i) ^ 8'hA5;
    end
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !reg_en && !i2c_valid, "R2 reset state",
          {124'd0, req_ready, rsp_valid, reg_en, i2c_valid}, 128'h8);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 native accesses
    run_req("R3 native write", 4'h8, 20'h00010, 4, pat(1), w);
    run_req("R3 native read", 4'h9, 20'h00010, 4, pat(2), w);
    run_req("R4 native read into error", 4'h9, 20'hEFFFE, 4, pat(3), w);
    run_req("R3 native write full", 4'h8, 20'h00020, 16, pat(4), w);
    run_req("R3 native read full", 4'h9, 20'h00020, 16, pat(5), w);
    run_req("R4 native write error first", 4'h8, 20'hF0003, 2, pat(6), w);

    // R1 unknown commands
    run_req("R1 unknown 3", 4'h3, 20'h00050, 2, pat(7), w);
    check(w == 2, "R1 reply latency", 128'(w), 128'd2);
    run_req("R1 unknown C", 4'hC, 20'h00050, 1, pat(8), w);
    run_req("R1 unknown 2", 4'h2, 20'h00050, 1, pat(8), w);

    // R5 R6 plain I2C
    run_req("R5 plain write", 4'h0, 20'h00050, 3, pat(9), w);
    run_req("R6 plain read no ack", 4'h1, 20'h00021, 2, pat(10), w);
    d = pat(11); d[15:8] = 8'hEE;
    run_req("R6 plain write byte nak", 4'h0, 20'h00051, 4, d, w);

    // R8 R9 R11 continuing requests
    run_req("R9 mot write open", 4'h4, 20'h00050, 2, pat(12), w);
    run_req("R8 mot write continue", 4'h4, 20'h00050, 3, pat(13), w);
    run_req("R8 mot read dir change", 4'h5, 20'h00050, 2, pat(14), w);
    run_req("R8 mot read addr change", 4'h5, 20'h00051, 1, pat(15), w);
    run_req("R11 mot read continue", 4'h5, 20'h00051, 4, pat(15), w);
    run_req("R5 plain read closes open", 4'h1, 20'h00050, 16, pat(16), w);

    // R10 byte failure inside continuing read
    run_req("R9 mot read open", 4'h5, 20'h00050, 1, pat(17), w);
    fail_k = 2;
    run_req("R10 mot read byte nak", 4'h5, 20'h00050, 4, pat(18), w);
    fail_k = 99;
    run_req("R10 mot after failure restarts", 4'h5, 20'h00050, 1, pat(19), w);

    // R7 start failures
    run_req("R7 mot start fail open", 4'h4, 20'h00022, 2, pat(20), w);
    run_req("R7 mot start fail closed", 4'h4, 20'h00023, 1, pat(21), w);
    run_req("R7 mot after fail", 4'h4, 20'h00050, 1, pat(22), w);
    run_req("R8 mot high address bits", 4'h4, 20'h10050, 1, pat(23), w);
    run_req("R8 mot same high address", 4'h4, 20'h10050, 2, pat(24), w);
    run_req("R6 plain write after mot", 4'h0, 20'h00051, 2, pat(25), w);
    run_req("R3 native readback", 4'h9, 20'h00000, 16, pat(26), w);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule